// File: doc/BRIEF.md
# Twisted-Ring Phase Sequencer

This block is a switch-tail shift register of `STAGES` flip-flops whose last stage is fed back inverted into the first. From an all-zero start it walks through `2*STAGES` distinct codes before it repeats. A plain ring of the same length gives only `STAGES` codes. Each code is turned into its own timing phase by a two-input AND of two stage outputs, so the phase outputs form a one-hot strobe train that rotates by one position on every enabled clock.

A synchronous reset puts the register at the all-zero code, where the first phase is active. A low shift enable freezes both the code and the phases. Codes that cannot be reached by shifting are detected. The next enabled clock after such a code is seen returns the register to all zeros, so a disturbed counter rejoins the legal cycle within one step.

With the default of four stages, the stages are called A, B, C and E. The raw code appears on `state_o` with A at bit 0 and E at bit 3.

Top module: `twisted_ring_seq`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the next state is `state_o = 4'b0000` and `phase_o = 8'b0000_0001`, whatever `shift_en_i` is.
- R2: On a rising edge with `shift_en_i` high and a legal state, stage i (i ≥ 1) takes the old value of stage i-1, and stage 0 (A, bit 0) takes the inverse of the old last stage (E, bit 3).
- R3: Starting from reset and shifting on every clock, `state_o` (A = bit 0) runs through 0, 1, 3, 7, 15, 14, 12, 8 and then returns to 0, for a period of 8 enabled clocks.
- R4: The phase outputs are formed from the stages as follows:
  - `phase_o[0]` = ~A & ~E
  - `phase_o[1]` = A & ~B
  - `phase_o[2]` = B & ~C
  - `phase_o[3]` = C & ~E
  - `phase_o[4]` = A & E
  - `phase_o[5]` = ~A & B
  - `phase_o[6]` = ~B & C
  - `phase_o[7]` = ~C & E
- R5: In every legal state exactly one phase bit is high. For the k-th code of the R3 list (k = 0..7), that bit is `phase_o[k]`, so each enabled step moves the high bit up by one position, wrapping from bit 7 to bit 0.
- R6: On a rising edge with `shift_en_i` low and `rst_i` low, `state_o` and `phase_o` keep their values.
- R7: An illegal state is any 4-bit code not in the R3 list (2, 4, 5, 6, 9, 10, 11, 13). Such a state is held while `shift_en_i` is low. The next rising edge with `shift_en_i` high loads 4'b0000.
- R8: Reset takes priority over a simultaneous shift enable in the middle of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| shift_en_i | input | 1 | Advance the sequence on this clock when high |
| state_o | output | STAGES | Raw stage contents, first stage at bit 0 |
| phase_o | output | 2*STAGES | One-hot decoded timing phases |

## Verification
The properties assume that `rst_i` and `shift_en_i` are clean synchronous levels that never carry X after the first edge. They also assume that the stage register changes only through its own next-state logic while reset is low. The stimulus changes every input on the falling clock edge. Illegal codes are planted in the register only during a cycle with reset asserted, and the force is released together with the reset, so no hold or shift property sees a jump that the logic did not make. Recovery from each of the eight unreachable codes is then driven purely through `shift_en_i`.

// File: rtl/twr_pkg.sv
package twr_pkg;
   // smallest ring that still gives two adjacent stages to decode
   localparam int unsigned TWR_MIN_STAGES = 2;

   // number of phases produced by a switch-tail ring of n stages
   function automatic int unsigned twr_phase_count(input int unsigned n);
      return 2 * n;
   endfunction
endpackage

// File: rtl/twr_code_check.sv
module twr_code_check #(
   parameter int unsigned STAGES = 4
) (
   input  logic [STAGES-1:0] state_i,
   output logic              legal_o
);
   localparam int unsigned EDGES = STAGES - 1;

   logic [EDGES-1:0] step_edge;

   // a reachable code has at most one place where neighbouring stages differ
   for (genvar i = 0; i < EDGES; i++) begin : g_edge
      assign step_edge[i] = state_i[i] ^ state_i[i+1];
   end

   assign legal_o = ($countones(step_edge) <= 1);
endmodule

// File: rtl/twr_shift_core.sv
module twr_shift_core #(
   parameter int unsigned STAGES  = 4,
   parameter bit          RECOVER = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              shift_en_i,
   input  logic              legal_i,
   output logic [STAGES-1:0] state_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] state_q;
   logic [STAGES-1:0] shifted;
   logic [STAGES-1:0] next_d;

   // stage 0 takes the inverted tail, every other stage its lower neighbour
   assign shifted[0] = ~state_q[LAST];
   for (genvar i = 1; i < STAGES; i++) begin : g_link
      assign shifted[i] = state_q[i-1];
   end

   if (RECOVER) begin : g_recover
      assign next_d = legal_i ? shifted : '0;
   end else begin : g_plain
      assign next_d = shifted;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= '0;
      end else if (shift_en_i) begin
         state_q <= next_d;
      end
   end

   assign state_o = state_q;

   // R2
   shift_rule_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (shift_en_i && legal_i) |=>
         (state_q[0] == !$past(state_q[LAST])) &&
         (state_q[LAST:1] == $past(state_q[LAST-1:0])));

   // R6
   hold_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !shift_en_i |=> $stable(state_q));

   if (RECOVER) begin : g_recover_chk
      // R7
      illegal_flush_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (shift_en_i && !legal_i) |=> (state_q == '0));
   end
endmodule

// File: rtl/twr_phase_decode.sv
module twr_phase_decode #(
   parameter int unsigned STAGES = 4
) (
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [STAGES-1:0]   state_i,
   input  logic                legal_i,
   output logic [2*STAGES-1:0] phase_o
);
   localparam int unsigned LAST = STAGES - 1;

   // both ends low, then each rising front, both ends high, each falling front
   assign phase_o[0]      = ~state_i[0] & ~state_i[LAST];
   assign phase_o[STAGES] =  state_i[0] &  state_i[LAST];

   for (genvar k = 1; k < STAGES; k++) begin : g_front
      assign phase_o[k]          =  state_i[k-1] & ~state_i[k];
      assign phase_o[STAGES + k] = ~state_i[k-1] &  state_i[k];
   end

   // R5
   one_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      legal_i |-> ($countones(phase_o) == 1));
endmodule

// File: rtl/twisted_ring_seq.sv
module twisted_ring_seq
   import twr_pkg::*;
#(
   parameter int unsigned STAGES  = 4,
   parameter bit          RECOVER = 1'b1
) (
   input  logic                                  clk_i,
   input  logic                                  rst_i,
   input  logic                                  shift_en_i,
   output logic [STAGES-1:0]                     state_o,
   output logic [twr_phase_count(STAGES)-1:0]    phase_o
);
   localparam int unsigned PHASES = twr_phase_count(STAGES);

   if (STAGES < TWR_MIN_STAGES) begin : g_bad_stages
      $error("twisted_ring_seq: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ring_state;
   logic              code_legal;

   twr_code_check #(.STAGES(STAGES)) u_check (
      .state_i (ring_state),
      .legal_o (code_legal)
   );

   twr_shift_core #(.STAGES(STAGES), .RECOVER(RECOVER)) u_core (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .shift_en_i (shift_en_i),
      .legal_i    (code_legal),
      .state_o    (ring_state)
   );

   twr_phase_decode #(.STAGES(STAGES)) u_decode (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .state_i (ring_state),
      .legal_i (code_legal),
      .phase_o (phase_o)
   );

   assign state_o = ring_state;

   // R5
   phase_rotate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (shift_en_i && code_legal) |=>
         (phase_o == {$past(phase_o[PHASES-2:0]), $past(phase_o[PHASES-1])}));
endmodule

// File: tb/tb_twisted_ring_seq.sv
module tb_twisted_ring_seq;
   logic       clk = 1'b0;
   logic       rst;
   logic       en;
   logic [3:0] state;
   logic [7:0] phase;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   twisted_ring_seq dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .shift_en_i (en),
      .state_o    (state),
      .phase_o    (phase)
   );

   // R3 sequence list
   function automatic logic [3:0] seq_code(input int k);
      int m;
      m = k % 8;
      if (m <= 4) return 4'((1 << m) - 1);
      return 4'(15 & ~((1 << (m - 4)) - 1));
   endfunction

   // R4 terms: A=bit0, B=bit1, C=bit2, E=bit3
   function automatic logic [7:0] terms(input logic [3:0] s);
      logic [7:0] p;
      p[0] = !s[0] && !s[3];
      p[1] =  s[0] && !s[1];
      p[2] =  s[1] && !s[2];
      p[3] =  s[2] && !s[3];
      p[4] =  s[0] &&  s[3];
      p[5] = !s[0] &&  s[1];
      p[6] = !s[1] &&  s[2];
      p[7] = !s[2] &&  s[3];
      return p;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; en = 1'b1;
      step();
      check("R1 state after reset", 32'(state), 32'h0);
      check("R1 phase after reset", 32'(phase), 32'h01);
      rst = 1'b0;
   endtask

   task automatic t_sequence();
      logic [3:0] prev;
      en = 1'b1;
      for (int k = 1; k <= 17; k++) begin
         prev = state;
         step();
         check("R3 code", 32'(state), 32'(seq_code(k)));
         check("R2 shift", 32'(state), 32'({prev[2:0], !prev[3]}));
         check("R5 phase", 32'(phase), 32'(8'h01 << (k % 8)));
         check("R4 terms", 32'(phase), 32'(terms(state)));
      end
   endtask

   task automatic t_hold();
      logic [3:0] s0;
      logic [7:0] p0;
      bit pat [8] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      s0 = state; p0 = phase;
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         check("R6 state held", 32'(state), 32'(s0));
         check("R6 phase held", 32'(phase), 32'(p0));
      end
      for (int i = 0; i < 8; i++) begin
         s0 = state; p0 = phase;
         en = pat[i];
         step();
         if (pat[i]) begin
            check("R2 gated shift", 32'(state), 32'({s0[2:0], !s0[3]}));
            check("R5 gated rotate", 32'(phase), 32'({p0[6:0], p0[7]}));
         end else begin
            check("R6 gated hold", 32'(state), 32'(s0));
         end
      end
   endtask

   task automatic t_reset_override();
      en = 1'b1;
      step(); step(); step();
      rst = 1'b1;
      step();
      check("R8 reset beats enable", 32'(state), 32'h0);
      check("R8 phase after reset", 32'(phase), 32'h01);
      rst = 1'b0;
   endtask

   task automatic t_illegal();
      logic [3:0] bad [8] = '{4'd2, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10, 4'd11, 4'd13};
      for (int i = 0; i < 8; i++) begin
         en = 1'b0; rst = 1'b1;
         force dut.u_core.state_q = bad[i];
         @(posedge clk);
         @(negedge clk);
         release dut.u_core.state_q;
         rst = 1'b0;
         check("R7 planted code", 32'(state), 32'(bad[i]));
         step();
         check("R7 illegal held", 32'(state), 32'(bad[i]));
         en = 1'b1;
         step();
         check("R7 flush to zero", 32'(state), 32'h0);
         check("R7 phase after flush", 32'(phase), 32'h01);
         step();
         check("R7 rejoins sequence", 32'(state), 32'h1);
      end
      en = 1'b0;
   endtask

   initial begin
      rst = 1'b1; en = 1'b0;
      @(negedge clk);
      t_reset();
      t_sequence();
      t_hold();
      t_reset_override();
      t_illegal();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule